// File: doc/BRIEF.md
# Partial Reconfiguration Control CSR Engine

This block is the hardware side of a host-driven partial reconfiguration controller. A host reaches it through six 64-bit word registers: control, status, data, error, and a low and a high interface-identifier word. The host uses a fixed sequence. It first runs a reset handshake. It then chooses a target region and requests a start. Next it pushes 32-bit configuration words, paced by a credit count. Finally it signals push-complete and waits for the hardware to drop the start bit.

Words the host pushes go into an internal buffer. A configuration sink drains the buffer at whatever rate it sets with its ready input. Each word the sink takes returns one credit to the host. Error conditions from the fabric arrive on an inject vector, and the block adds its own overflow and protocol errors. All of these latch into a sticky error register, and the host clears it by writing back the bits it wants cleared.

Top module: `prcfg_engine`

## Requirements
- R1: After reset the control and error registers read 0. The status register reads with credits (bits 8:0) equal to DEPTH, operation-error flag (bit 16) 0, controller status (bits 22:20) 0 and host status (bits 27:24) 0.
- R2: Writing control with bit 0 set makes bit 0 and the acknowledge bit 4 read 1 from the next cycle, with host status 1. Writing bit 0 clear then makes bits 0 and 4 read 0 and host status return to 0 (idle).
- R3: In idle, a control write with bit 12 set starts an operation. Bit 12 then reads 1, region bits 9:8 and kind bit 14 hold the written values, controller status reads 2 and host status reads 2. Bits 63:32 read back the last value written there.
- R4: While an operation is loading, each data-register write (word address 2, word in bits 31:0) puts one word into the buffer and lowers credits by one. The sink receives the words in write order, and each word drained returns one credit.
- R5: A control write with bit 13 set during loading moves the engine to drain (controller status 3). Bits 12 and 13 clear only once the buffer is empty, and that happens within two cycles of the last word leaving.
- R6: Credits never exceed DEPTH. A data write while loading with zero credits is dropped and sets error bit 4.
- R7: Error bits are sticky. Inject bits 0 to 3 and 6 set the error bits of the same index, and bit 5 always reads 0. Status bit 16 reads 1 exactly when any error bit is 1.
- R8: A write to the error register (word address 3) clears exactly the bits written as 1. A set arriving in the same cycle wins.
- R9: Words 4 and 5 read the ID_LO and ID_HI parameters. Writes to status (address 1) and to the ID words have no effect, and reserved bits read 0.
- R10: A data write outside the loading state is dropped, leaves the credits unchanged and sets error bit 3 (protocol error).
- R11: A reset request during an operation aborts it. Bit 12 clears and the buffer is flushed, so credits return to DEPTH and no buffered word reaches the sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Register word address (0 ctl, 1 status, 2 data, 3 error, 4 ID low, 5 ID high) |
| hostWrData | input | 64 | Host write data |
| hostRdData | output | 64 | Read data for hostAddr, combinational |
| sinkValid | output | 1 | Buffer holds a word for the sink |
| sinkReady | input | 1 | Sink takes the head word this cycle |
| sinkWord | output | 32 | Head word of the buffer |
| regionId | output | 2 | Target region of the current operation |
| imageKind | output | 1 | Image kind of the current operation |
| errInject | input | 7 | Fabric error pulses, one per error bit |

## Verification
A wrong credit count shows up as status bits 8:0 going wrong on the next read. It also shows up as overflow flagged too early or too late, or as the sink receiving more or fewer words than the host pushed. A sequencer stuck in the wrong state shows as bit 12 never falling after push-complete, or falling before the buffer is empty. It can also show as data writes being counted as protocol errors. A corrupted error register shows on the first error read after the disturbing write or inject pulse, and the status error flag follows it in the same read.

// File: rtl/prcfg_pkg.sv
`timescale 1ns/1ps
package prcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RESET = 3'd1,
    ST_LOAD  = 3'd2,
    ST_DRAIN = 3'd3
  } engState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic pushWord;
    logic dropOvf;
    logic protoErr;
    logic flushBuf;
    logic errClr;
  } dpStrobe_t;

  localparam logic [2:0] ADDR_CTL  = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_DATA = 3'd2;
  localparam logic [2:0] ADDR_ERR  = 3'd3;
  localparam logic [2:0] ADDR_IDLO = 3'd4;
  localparam logic [2:0] ADDR_IDHI = 3'd5;

  localparam int ERR_W = 7;
  localparam logic [ERR_W-1:0] ERR_VALID = 7'b101_1111;
  localparam int ERR_PROTO_BIT = 3;
  localparam int ERR_OVF_BIT   = 4;

  localparam logic [3:0] HOST_IDLE      = 4'd0;
  localparam logic [3:0] HOST_RESETTING = 4'd1;
  localparam logic [3:0] HOST_BUSY      = 4'd2;
endpackage

// File: rtl/prcfg_ctrl.sv
`timescale 1ns/1ps
module prcfg_ctrl
  import prcfg_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [2:0]    hostAddr,
  input  logic          wrResetReq,
  input  logic          wrStart,
  input  logic          wrPushDone,
  input  logic [1:0]    wrRegion,
  input  logic          wrKind,
  input  logic [31:0]   wrCfgData,
  input  logic [CW-1:0] creditCnt,
  output dpStrobe_t     strb,
  output logic [63:0]   ctlWord,
  output logic [2:0]    ctrlStat,
  output logic [3:0]    hostStat,
  output logic [1:0]    regionId,
  output logic          imageKind,
  output logic          resetAck,
  output logic          startReq
);
  engState_t state;
  logic pushDone;
  logic [31:0] cfgData;
  logic ctlWr, dataWr, bufEmpty;

  assign ctlWr    = hostWrEn && (hostAddr == ADDR_CTL);
  assign dataWr   = hostWrEn && (hostAddr == ADDR_DATA);
  assign bufEmpty = (creditCnt == CW'(DEPTH));
  assign resetAck = (state == ST_RESET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startReq  <= 1'b0;
      pushDone  <= 1'b0;
      regionId  <= '0;
      imageKind <= 1'b0;
      cfgData   <= '0;
    end else begin
      if (ctlWr) cfgData <= wrCfgData;
      unique case (state)
        ST_IDLE: begin
          if (ctlWr && wrResetReq) begin
            state <= ST_RESET;
          end else if (ctlWr && wrStart) begin
            state     <= ST_LOAD;
            startReq  <= 1'b1;
            regionId  <= wrRegion;
            imageKind <= wrKind;
          end
        end
        ST_LOAD: begin
          if (ctlWr && wrResetReq) begin
            state    <= ST_RESET;
            startReq <= 1'b0;
          end else if (ctlWr && wrPushDone) begin
            state    <= ST_DRAIN;
            pushDone <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (ctlWr && wrResetReq) begin
            state    <= ST_RESET;
            startReq <= 1'b0;
            pushDone <= 1'b0;
          end else if (bufEmpty) begin
            state    <= ST_IDLE;
            startReq <= 1'b0;
            pushDone <= 1'b0;
          end
        end
        ST_RESET: begin
          if (ctlWr && !wrResetReq) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.pushWord = dataWr && (state == ST_LOAD) && !bufEmptyCredit0();
    strb.dropOvf  = dataWr && (state == ST_LOAD) && bufEmptyCredit0();
    strb.protoErr = dataWr && (state != ST_LOAD);
    strb.flushBuf = (state == ST_RESET) || (ctlWr && wrResetReq);
    strb.errClr   = hostWrEn && (hostAddr == ADDR_ERR);
  end

  function automatic logic bufEmptyCredit0();
    return (creditCnt == '0);
  endfunction

  always_comb begin
    ctlWord        = '0;
    ctlWord[0]     = resetAck;
    ctlWord[4]     = resetAck;
    ctlWord[9:8]   = regionId;
    ctlWord[12]    = startReq;
    ctlWord[13]    = pushDone;
    ctlWord[14]    = imageKind;
    ctlWord[63:32] = cfgData;
  end

  assign ctrlStat = state;

  always_comb begin
    unique case (state)
      ST_RESET:          hostStat = HOST_RESETTING;
      ST_LOAD, ST_DRAIN: hostStat = HOST_BUSY;
      default:           hostStat = HOST_IDLE;
    endcase
  end
endmodule

// File: rtl/prcfg_datapath.sv
`timescale 1ns/1ps
module prcfg_datapath
  import prcfg_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [31:0]      wordIn,
  input  logic [ERR_W-1:0] clrMask,
  input  logic [ERR_W-1:0] errInject,
  input  logic             sinkReady,
  output logic             sinkValid,
  output logic [31:0]      sinkWord,
  output logic [CW-1:0]    creditCnt,
  output logic [ERR_W-1:0] errBits
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] occ;
  logic          popFire;
  logic [ERR_W-1:0] errSet, errKeep;

  assign sinkValid = (occ != '0) && !strb.flushBuf;
  assign popFire   = sinkValid && sinkReady;
  assign sinkWord  = mem[rdPtr];
  assign creditCnt = CW'(DEPTH) - occ;

  always_ff @(posedge clk) begin
    if (strb.pushWord) mem[wrPtr] <= wordIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flushBuf) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strb.pushWord) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (popFire)       rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      occ <= occ + CW'(strb.pushWord) - CW'(popFire);
    end
  end

  always_comb begin
    errSet = errInject;
    errSet[ERR_OVF_BIT]   = errInject[ERR_OVF_BIT] | strb.dropOvf;
    errSet[ERR_PROTO_BIT] = errInject[ERR_PROTO_BIT] | strb.protoErr;
    errKeep = strb.errClr ? (errBits & ~clrMask) : errBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errBits <= '0;
    else       errBits <= (errKeep | errSet) & ERR_VALID;
  end
endmodule

// File: rtl/prcfg_engine.sv
`timescale 1ns/1ps
module prcfg_engine
  import prcfg_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [63:0] ID_LO = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_HI = 64'hFEDC_BA98_7654_3210
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [2:0]  hostAddr,
  input  logic [63:0] hostWrData,
  output logic [63:0] hostRdData,
  output logic        sinkValid,
  input  logic        sinkReady,
  output logic [31:0] sinkWord,
  output logic [1:0]  regionId,
  output logic        imageKind,
  input  logic [6:0]  errInject
);
  localparam int CW = $clog2(DEPTH + 1);

  dpStrobe_t strb;
  logic [CW-1:0] creditCnt;
  logic [ERR_W-1:0] errBits;
  logic [63:0] ctlWord, statWord;
  logic [2:0] ctrlStat;
  logic [3:0] hostStat;
  logic resetAck, startReq;
  logic unusedBits;

  assign unusedBits = ^{hostWrData[31:15], hostWrData[11:10], hostWrData[7:1]};

  prcfg_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .wrResetReq(hostWrData[0]), .wrStart(hostWrData[12]),
    .wrPushDone(hostWrData[13]), .wrRegion(hostWrData[9:8]),
    .wrKind(hostWrData[14]), .wrCfgData(hostWrData[63:32]),
    .creditCnt(creditCnt), .strb(strb), .ctlWord(ctlWord),
    .ctrlStat(ctrlStat), .hostStat(hostStat), .regionId(regionId),
    .imageKind(imageKind), .resetAck(resetAck), .startReq(startReq)
  );

  prcfg_datapath #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIn(hostWrData[31:0]),
    .clrMask(hostWrData[ERR_W-1:0]), .errInject(errInject),
    .sinkReady(sinkReady), .sinkValid(sinkValid), .sinkWord(sinkWord),
    .creditCnt(creditCnt), .errBits(errBits)
  );

  always_comb begin
    statWord        = '0;
    statWord[CW-1:0] = creditCnt;
    statWord[16]    = |errBits;
    statWord[22:20] = ctrlStat;
    statWord[27:24] = hostStat;
  end

  always_comb begin
    unique case (hostAddr)
      ADDR_CTL:  hostRdData = ctlWord;
      ADDR_STAT: hostRdData = statWord;
      ADDR_ERR:  hostRdData = {{(64-ERR_W){1'b0}}, errBits};
      ADDR_IDLO: hostRdData = ID_LO;
      ADDR_IDHI: hostRdData = ID_HI;
      default:   hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/prcfg_engine_chk.sv
`timescale 1ns/1ps
module prcfg_engine_chk
  import prcfg_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrEn,
  input logic [2:0]       hostAddr,
  input logic [63:0]      hostWrData,
  input logic [6:0]       errInject,
  input logic [CW-1:0]    creditCnt,
  input logic             resetAck,
  input logic             startReq,
  input logic [ERR_W-1:0] errBits
);
  // R2
  reset_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_CTL && hostWrData[0]) |=> resetAck);

  // R5
  done_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startReq) |-> (creditCnt == CW'(DEPTH)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    creditCnt <= CW'(DEPTH));

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostAddr == ADDR_ERR) |=> ((errBits & $past(errBits)) == $past(errBits)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_ERR && errInject == '0)
      |=> ((errBits & $past(hostWrData[ERR_W-1:0])) == '0));
endmodule

bind prcfg_engine prcfg_engine_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/prcfg_engine_bench.sv
`timescale 1ns/1ps
module prcfg_engine_bench;
  localparam int DEPTH = 256;
  localparam logic [63:0] IDL = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] IDH = 64'hFEDC_BA98_7654_3210;

  logic clk = 1'b0, rstN = 1'b0, hostWrEn = 1'b0, sinkReady = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [63:0] hostWrData = '0, hostRdData;
  logic sinkValid, imageKind;
  logic [31:0] sinkWord;
  logic [1:0] regionId;
  logic [6:0] errInject = '0;

  int checks = 0, errors = 0;
  logic [31:0] got [0:1023];
  int gotN = 0;

  always #10 clk = ~clk;

  prcfg_engine #(.DEPTH(DEPTH), .ID_LO(IDL), .ID_HI(IDH)) u_prcfg_engine (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .sinkValid(sinkValid),
    .sinkReady(sinkReady), .sinkWord(sinkWord), .regionId(regionId),
    .imageKind(imageKind), .errInject(errInject));

  always begin
    @(negedge clk);
    #5;
    if (sinkValid && sinkReady && gotN < 1024) begin
      got[gotN] = sinkWord;
      gotN++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] stat(input int cr, input bit err, input int cs, input int hs);
    return (64'(hs) << 24) | (64'(cs) << 20) | (64'(err) << 16) | 64'(cr);
  endfunction

  task automatic t_reset_state();
    logic [63:0] v;
    rd(0, v); chk("R1 ctl", v, 0);
    rd(1, v); chk("R1 status", v, stat(DEPTH, 0, 0, 0));
    rd(3, v); chk("R1 err", v, 0);
  endtask

  task automatic t_handshake();
    logic [63:0] v;
    wr(0, 64'h1);
    rd(0, v); chk("R2 ack set", v, 64'h11);
    rd(1, v); chk("R2 resetting", v, stat(DEPTH, 0, 1, 1));
    wr(0, 64'h0);
    rd(0, v); chk("R2 ack clear", v, 0);
    rd(1, v); chk("R2 host idle", v, stat(DEPTH, 0, 0, 0));
  endtask

  task automatic t_load_drain();
    logic [63:0] v, c;
    int base;
    c = (64'hA5A5 << 32) | (64'h1 << 14) | (64'h1 << 12) | (64'h2 << 8);
    sinkReady = 1'b0;
    wr(0, c);
    rd(0, v); chk("R3 ctl", v, c);
    rd(1, v); chk("R3 status", v, stat(DEPTH, 0, 2, 2));
    chk("R3 region pin", {62'b0, regionId}, 2);
    base = gotN;
    for (int i = 0; i < 5; i++) wr(2, 64'(32'hC0DE_0000 + i));
    rd(1, v); chk("R4 credits", v, stat(DEPTH - 5, 0, 2, 2));
    wr(0, c | (64'h1 << 13));
    idle(5);
    rd(0, v); chk("R5 start held", v, c | (64'h1 << 13));
    rd(1, v); chk("R5 drain status", v, stat(DEPTH - 5, 0, 3, 2));
    sinkReady = 1'b1;
    idle(12);
    rd(0, v); chk("R5 start cleared", v, (64'hA5A5 << 32) | (64'h1 << 14) | (64'h2 << 8));
    rd(1, v); chk("R4 credits back", v, stat(DEPTH, 0, 0, 0));
    chk("R4 count", 64'(gotN - base), 5);
    for (int i = 0; i < 5; i++) chk("R4 order", 64'(got[base + i]), 64'(32'hC0DE_0000 + i));
    rd(3, v); chk("R7 no err", v, 0);
  endtask

  task automatic t_overflow();
    logic [63:0] v;
    int base;
    sinkReady = 1'b0;
    wr(0, 64'h1000);
    base = gotN;
    for (int i = 0; i < DEPTH; i++) wr(2, 64'(i));
    rd(1, v); chk("R6 zero credits", v, stat(0, 0, 2, 2));
    wr(2, 64'hDEAD);
    rd(3, v); chk("R6 ovf bit", v, 64'h10);
    rd(1, v); chk("R7 op flag", v, stat(0, 1, 2, 2));
    sinkReady = 1'b1;
    idle(DEPTH + 10);
    chk("R6 dropped", 64'(gotN - base), DEPTH);
    chk("R6 last word", 64'(got[base + DEPTH - 1]), DEPTH - 1);
    wr(0, 64'h3000);
    idle(4);
    rd(0, v); chk("R5 done", v, 0);
  endtask

  task automatic t_proto();
    logic [63:0] v;
    int base;
    base = gotN;
    wr(2, 64'h1234);
    rd(3, v); chk("R10 proto bit", v, 64'h18);
    rd(1, v); chk("R10 credits kept", v, stat(DEPTH, 1, 0, 0));
    idle(3);
    chk("R10 no sink word", 64'(gotN - base), 0);
  endtask

  task automatic t_w1c();
    logic [63:0] v;
    @(negedge clk); errInject = 7'b110_0010;
    @(negedge clk); errInject = '0;
    rd(3, v); chk("R7 inject", v, 64'h5A);
    wr(3, 64'h08);
    rd(3, v); chk("R8 partial clear", v, 64'h52);
    wr(3, 64'h52);
    rd(3, v); chk("R8 full clear", v, 0);
    rd(1, v); chk("R7 flag clear", v, stat(DEPTH, 0, 0, 0));
  endtask

  task automatic t_readonly();
    logic [63:0] v;
    wr(1, '1);
    wr(4, '1);
    wr(5, 64'h0);
    rd(1, v); chk("R9 status ro", v, stat(DEPTH, 0, 0, 0));
    rd(4, v); chk("R9 id low", v, IDL);
    rd(5, v); chk("R9 id high", v, IDH);
    rd(0, v); chk("R9 ctl reserved", v, 0);
  endtask

  task automatic t_abort();
    logic [63:0] v;
    int base;
    sinkReady = 1'b0;
    wr(0, 64'h1100);
    for (int i = 0; i < 3; i++) wr(2, 64'(i + 7));
    base = gotN;
    wr(0, 64'h1);
    rd(0, v); chk("R11 aborted", v, 64'h111);
    rd(1, v); chk("R11 flushed", v, stat(DEPTH, 0, 1, 1));
    sinkReady = 1'b1;
    wr(0, 64'h0);
    idle(6);
    chk("R11 nothing sunk", 64'(gotN - base), 0);
    rd(1, v); chk("R11 idle", v, stat(DEPTH, 0, 0, 0));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset_state();
    t_handshake();
    t_load_drain();
    t_overflow();
    t_proto();
    t_w1c();
    t_readonly();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule